// File: doc/BRIEF.md
# Level-1 Data Cache Lookup with Early Set Read

This block is the read path of a 4-way set-associative level-1 data cache. A requester presents only the page-offset bits of a virtual address. Those bits do not change under translation, so the block starts the set read in the cycle it accepts the request, while the translation unit is still working on the page number. The physical page number comes later on its own handshake. The block then compares it with the tags of the ways it has already read. A hit returns the addressed 32-bit word. A miss emits a one-cycle request to the next memory level that carries the full physical address. A translation fault cancels the lookup quietly.

Only one lookup can be in flight at a time. Line contents come from an external refill engine through a plain line-write port. Replacement choice, refill sequencing, writes and coherence are outside this block.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and miss_valid are 0, and every line is invalid, so the first lookup to any set misses.
- R2: The set is selected by page-offset bits [11:5] of the request (bits [4:0] are the byte offset in a 32-byte line). A lookup reads only that set, so a line filled into a different set never hits.
- R3: req_ready is 0 from the cycle after a request is accepted until the cycle the result or cancellation appears. It is 1 in that cycle.
- R4: xlat_valid is ignored while no lookup is outstanding. It produces no response and no miss, and it leaves req_ready at 1.
- R5: When a valid way holds a tag equal to the translated page number, rsp_valid pulses in the cycle after the translation handshake. rsp_data is then word number ofs[4:2] of the line, where word i occupies line bits [32*i+31:32*i].
- R6: When no valid way matches, miss_valid pulses in the cycle after the translation handshake, with miss_paddr = {xlat_ppn, the 12 page-offset bits of the request}.
- R7: A translation handshake with xlat_fault = 1 ends the lookup with neither rsp_valid nor miss_valid, and req_ready returns to 1 in the next cycle.
- R8: fill_en writes fill_tag and fill_line into way fill_way of set fill_set and marks that way valid. This affects lookups accepted after the fill cycle, and it replaces the previous tag of that way.
- R9: A valid line in the selected set whose tag differs from the translated page number does not hit.
- R10: rsp_valid and miss_valid are never high together, and each stays high for exactly one cycle per lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_page_ofs | input | 12 | Untranslated page-offset bits of the address |
| xlat_valid | input | 1 | Translation result strobe |
| xlat_fault | input | 1 | Translation failed; cancel the lookup |
| xlat_ppn | input | 20 | Translated physical page number |
| rsp_valid | output | 1 | Hit result strobe |
| rsp_data | output | 32 | Word read on a hit |
| miss_valid | output | 1 | Next-level request strobe |
| miss_paddr | output | 32 | Physical address of the missed word |
| fill_en | input | 1 | Line write strobe from the refill engine |
| fill_way | input | 2 | Way to write |
| fill_set | input | 7 | Set to write |
| fill_tag | input | 20 | Tag to store |
| fill_line | input | 256 | Line data to store |

## Verification
A stale or wrong valid bit appears at the ports in the cycle after the translation handshake, as a miss where a hit was due or the reverse. A wrong held set index or word select gives a wrong rsp_data value in that same cycle. A sticking lookup state shows in the cycle after acceptance, as req_ready staying high or failing to return. A mishandled fault shows one cycle after the translation handshake, as an unexpected output pulse. The scoreboard models the contents of every line from the fills it drives. It therefore checks each hit word and each miss address against that model, and it flags any pulse it did not expect.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [0:0] {
    LK_IDLE = 1'b0,
    LK_WAIT = 1'b1
  } lk_state_e;
endpackage

// File: rtl/vipt_way_ram.sv
module vipt_way_ram #(
  parameter int SET_W  = 7,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              rd_en,
  input  logic [SET_W-1:0]  rd_set,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line
);
  localparam int SETS = 1 << SET_W;

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set]  <= wr_tag;
      line_mem[wr_set] <= wr_line;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_set];
      rd_line <= line_mem[rd_set];
    end
  end
endmodule

// File: rtl/vipt_tag_match.sv
module vipt_tag_match #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 256,
  parameter int WORD_W = 32,
  parameter int WSEL_W = 3
) (
  input  logic [WAYS*TAG_W-1:0]  way_tags,
  input  logic [WAYS*LINE_W-1:0] way_lines,
  input  logic [WAYS-1:0]        way_valid,
  input  logic [TAG_W-1:0]       cmp_tag,
  input  logic [WSEL_W-1:0]      word_sel,
  output logic                   hit,
  output logic [WORD_W-1:0]      hit_word
);
  logic [WAYS-1:0]   way_hit;
  logic [WORD_W-1:0] way_word [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w]  = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == cmp_tag);
    assign way_word[w] = way_lines[w*LINE_W + int'(word_sel)*WORD_W +: WORD_W];
  end

  always_comb begin
    hit_word = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_word = hit_word | way_word[w];
    end
  end

  assign hit = |way_hit;
endmodule

// File: rtl/vipt_lookup_ctrl.sv
module vipt_lookup_ctrl
  import vipt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic xlat_valid,
  output logic req_ready,
  output logic take_req,
  output logic resolve
);
  lk_state_e state_q;

  assign req_ready = (state_q == LK_IDLE);
  assign take_req  = req_valid && req_ready;
  assign resolve   = (state_q == LK_WAIT) && xlat_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LK_IDLE;
    end else begin
      case (state_q)
        LK_IDLE: if (take_req) state_q <= LK_WAIT;
        LK_WAIT: if (xlat_valid) state_q <= LK_IDLE;
        default: state_q <= LK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup #(
  parameter int PA_W       = 32,
  parameter int PAGE_OFS_W = 12,
  parameter int SET_W      = 7,
  parameter int LOFS_W     = 5,
  parameter int WAYS       = 4,
  parameter int WORD_W     = 32,
  localparam int PPN_W  = PA_W - PAGE_OFS_W,
  localparam int TAG_W  = PA_W - SET_W - LOFS_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = 8 << LOFS_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [PAGE_OFS_W-1:0] req_page_ofs,
  input  logic                  xlat_valid,
  input  logic                  xlat_fault,
  input  logic [PPN_W-1:0]      xlat_ppn,
  output logic                  rsp_valid,
  output logic [WORD_W-1:0]     rsp_data,
  output logic                  miss_valid,
  output logic [PA_W-1:0]       miss_paddr,
  input  logic                  fill_en,
  input  logic [WAY_W-1:0]      fill_way,
  input  logic [SET_W-1:0]      fill_set,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic [LINE_W-1:0]     fill_line
);
  localparam int SETS   = 1 << SET_W;
  localparam int SET_HI = SET_W + LOFS_W;
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = LOFS_W - BYTE_W;
  localparam int GAP_W  = PAGE_OFS_W - SET_HI;

  if (SET_HI > PAGE_OFS_W) begin : g_bad_geometry
    $error("set index and line offset must fit inside the page offset");
  end

  logic                  take_req;
  logic                  resolve;
  logic [PAGE_OFS_W-1:0] held_ofs;
  logic [SET_W-1:0]      held_set;
  logic [TAG_W-1:0]      cmp_tag;
  logic [WAYS*TAG_W-1:0]  way_tags;
  logic [WAYS*LINE_W-1:0] way_lines;
  logic [WAYS-1:0]       valid_q [SETS];
  logic                  hit;
  logic [WORD_W-1:0]     hit_word;

  vipt_lookup_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .xlat_valid(xlat_valid),
    .req_ready (req_ready),
    .take_req  (take_req),
    .resolve   (resolve)
  );

  // Page offset is translation-invariant: latch it with the request.
  always_ff @(posedge clk) begin
    if (take_req) held_ofs <= req_page_ofs;
  end

  assign held_set = held_ofs[SET_HI-1:LOFS_W];

  if (GAP_W == 0) begin : g_tag_ppn
    assign cmp_tag = xlat_ppn;
  end else begin : g_tag_ext
    assign cmp_tag = {xlat_ppn, held_ofs[PAGE_OFS_W-1:SET_HI]};
  end

  // One tag/data RAM per way, read with the untranslated index.
  for (genvar w = 0; w < WAYS; w++) begin : g_ways
    vipt_way_ram #(
      .SET_W (SET_W),
      .TAG_W (TAG_W),
      .LINE_W(LINE_W)
    ) u_ram (
      .clk    (clk),
      .wr_en  (fill_en && (fill_way == WAY_W'(w))),
      .wr_set (fill_set),
      .wr_tag (fill_tag),
      .wr_line(fill_line),
      .rd_en  (take_req),
      .rd_set (req_page_ofs[SET_HI-1:LOFS_W]),
      .rd_tag (way_tags[w*TAG_W +: TAG_W]),
      .rd_line(way_lines[w*LINE_W +: LINE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (fill_en) begin
      valid_q[fill_set][fill_way] <= 1'b1;
    end
  end

  vipt_tag_match #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .LINE_W(LINE_W),
    .WORD_W(WORD_W),
    .WSEL_W(WSEL_W)
  ) u_match (
    .way_tags (way_tags),
    .way_lines(way_lines),
    .way_valid(valid_q[held_set]),
    .cmp_tag  (cmp_tag),
    .word_sel (held_ofs[LOFS_W-1:BYTE_W]),
    .hit      (hit),
    .hit_word (hit_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      miss_valid <= 1'b0;
    end else begin
      rsp_valid  <= resolve && !xlat_fault && hit;
      miss_valid <= resolve && !xlat_fault && !hit;
    end
  end

  always_ff @(posedge clk) begin
    if (resolve) begin
      rsp_data   <= hit_word;
      miss_paddr <= {xlat_ppn, held_ofs};
    end
  end
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk #(
  parameter int PA_W       = 32,
  parameter int PAGE_OFS_W = 12
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic                         xlat_valid,
  input logic                         xlat_fault,
  input logic [PA_W-PAGE_OFS_W-1:0]   xlat_ppn,
  input logic                         rsp_valid,
  input logic                         miss_valid,
  input logic [PA_W-1:0]              miss_paddr
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> req_ready && !rsp_valid && !miss_valid);

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  a_r3_ready_with_result: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || miss_valid) |-> req_ready);

  a_r4_result_needs_xlat: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || miss_valid) |-> $past(xlat_valid && !xlat_fault && !req_ready));

  a_r6_miss_page: assert property (@(posedge clk) disable iff (rst)
    miss_valid |-> miss_paddr[PA_W-1:PAGE_OFS_W] == $past(xlat_ppn));

  a_r7_fault_silent: assert property (@(posedge clk) disable iff (rst)
    xlat_valid && xlat_fault && !req_ready |=> !rsp_valid && !miss_valid && req_ready);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && miss_valid));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || miss_valid) |=> !rsp_valid && !miss_valid);
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk #(
  .PA_W      (PA_W),
  .PAGE_OFS_W(PAGE_OFS_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .xlat_valid(xlat_valid),
  .xlat_fault(xlat_fault),
  .xlat_ppn  (xlat_ppn),
  .rsp_valid (rsp_valid),
  .miss_valid(miss_valid),
  .miss_paddr(miss_paddr)
);

// File: tb/test_vipt_l1_lookup.sv
`timescale 1ns/1ps
module test_vipt_l1_lookup;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [11:0]  req_page_ofs = '0;
  logic         xlat_valid = 1'b0;
  logic         xlat_fault = 1'b0;
  logic [19:0]  xlat_ppn = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_data;
  logic         miss_valid;
  logic [31:0]  miss_paddr;
  logic         fill_en = 1'b0;
  logic [1:0]   fill_way = '0;
  logic [6:0]   fill_set = '0;
  logic [19:0]  fill_tag = '0;
  logic [255:0] fill_line = '0;

  always #2.5 clk = ~clk;

  vipt_l1_lookup i_vipt_l1_lookup (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_page_ofs(req_page_ofs), .xlat_valid(xlat_valid), .xlat_fault(xlat_fault),
    .xlat_ppn(xlat_ppn), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .miss_valid(miss_valid), .miss_paddr(miss_paddr), .fill_en(fill_en),
    .fill_way(fill_way), .fill_set(fill_set), .fill_tag(fill_tag), .fill_line(fill_line)
  );

  typedef struct {
    bit          is_hit;
    logic [31:0] data;
    logic [31:0] paddr;
    string       req;
  } exp_t;

  exp_t         sb_q[$];
  int           checks = 0;
  int           errors = 0;
  bit           m_val  [128][4];
  logic [19:0]  m_tag  [128][4];
  logic [255:0] m_line [128][4];
  bit           prev_out = 1'b0;

  function automatic logic [255:0] mk_line(int seed);
    logic [255:0] l;
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = 32'(seed) * 32'h100 + 32'(i) + 32'hA000_0000;
    return l;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(int set, int way, logic [19:0] tag, int seed);
    @(negedge clk);
    fill_en = 1'b1; fill_set = 7'(set); fill_way = 2'(way);
    fill_tag = tag; fill_line = mk_line(seed);
    m_val[set][way] = 1'b1; m_tag[set][way] = tag; m_line[set][way] = mk_line(seed);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // Driver: predicts the outcome from the line model, then runs the handshakes.
  task automatic lookup(logic [11:0] ofs, logic [19:0] ppn, bit fault, int gap, string req);
    exp_t e;
    int   set;
    while (!req_ready) @(negedge clk);
    set = int'(ofs[11:5]);
    e.is_hit = 1'b0; e.data = '0; e.req = req;
    e.paddr = {ppn, ofs};
    for (int w = 0; w < 4; w++) begin
      if (m_val[set][w] && m_tag[set][w] == ppn) begin
        e.is_hit = 1'b1;
        e.data   = m_line[set][w][int'(ofs[4:2])*32 +: 32];
      end
    end
    if (!fault) sb_q.push_back(e);
    req_valid = 1'b1; req_page_ofs = ofs;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R3", "ready after accept", 32'(req_ready), 0);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check(!req_ready, "R3", "ready while waiting", 32'(req_ready), 0);
    end
    xlat_valid = 1'b1; xlat_fault = fault; xlat_ppn = ppn;
    @(negedge clk);
    xlat_valid = 1'b0; xlat_fault = 1'b0;
    check(req_ready, fault ? "R7" : "R3", "ready after translation", 32'(req_ready), 1);
  endtask

  // Monitor: pops the scoreboard on every output pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_out) check(!(rsp_valid || miss_valid), "R10", "pulse width",
                          {30'b0, rsp_valid, miss_valid}, 0);
      prev_out = rsp_valid || miss_valid;
      if (rsp_valid || miss_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R4/R7", "unexpected output", {30'b0, rsp_valid, miss_valid}, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (e.is_hit) begin
            check(rsp_valid && !miss_valid, e.req, "hit strobe", {30'b0, rsp_valid, miss_valid}, 2);
            check(rsp_data == e.data, e.req, "hit word", rsp_data, e.data);
          end else begin
            check(miss_valid && !rsp_valid, e.req, "miss strobe", {30'b0, rsp_valid, miss_valid}, 1);
            check(miss_paddr == e.paddr, e.req, "miss address", miss_paddr, e.paddr);
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 128; s++) for (int w = 0; w < 4; w++) m_val[s][w] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !miss_valid, "R1", "reset state",
          {29'b0, req_ready, rsp_valid, miss_valid}, 4);
    lookup(12'h0A4, 20'h12345, 0, 0, "R1");
    do_fill(5, 0, 20'h12345, 1);
    lookup(12'h0AC, 20'h12345, 0, 0, "R5_R8");
    lookup(12'h0A0, 20'h12345, 0, 3, "R5");
    lookup(12'h0BC, 20'h12345, 0, 1, "R5");
    lookup(12'h0A8, 20'hABCDE, 0, 0, "R9_R6");
    do_fill(5, 3, 20'hABCDE, 2);
    lookup(12'h0A8, 20'hABCDE, 0, 0, "R8");
    lookup(12'h0A8, 20'hABCDE, 1, 2, "R7");
    repeat (2) @(negedge clk);
    // R4: stray translation while idle
    xlat_valid = 1'b1; xlat_ppn = 20'h12345;
    @(negedge clk);
    xlat_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(req_ready, "R4", "ready after stray translation", 32'(req_ready), 1);
    lookup(12'h0B0, 20'h12345, 0, 0, "R4");
    do_fill(0, 1, 20'h00777, 3);
    do_fill(127, 2, 20'h00777, 4);
    lookup(12'h000, 20'h00777, 0, 0, "R2");
    lookup(12'hFFC, 20'h00777, 0, 0, "R2");
    lookup(12'h0E0, 20'h00777, 0, 0, "R2");
    do_fill(5, 0, 20'h55555, 5);
    lookup(12'h0AC, 20'h12345, 0, 0, "R8");
    lookup(12'h0AC, 20'h55555, 0, 0, "R8");
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R5/R6", "outstanding results", sb_q.size(), 0);
    finish_run();
  end
endmodule